// File: doc/BRIEF.md
# Power and Reset Mode Controller

This block sequences a chip between its three operating modes and turns three asynchronous, active-low reset inputs into two reset outputs. A Run mode enables every clock. A Halt mode stops only the processor clock while peripherals keep working. A Standby mode shuts down the main oscillator, the bus and peripheral clocks and the display. A wake event, such as a key press, leaves Halt or Standby for Run. Software in Run asks for Halt or Standby with a two-bit command.

The reset outputs are split by source. A power-on reset drives both the full-domain reset and the partial-domain reset. A power-fail or user reset drives only the partial-domain reset, so the memory-controller and real-time-clock state survive it. Before such a partial reset is applied, the block asks the SDRAM controller to enter self-refresh and waits for its acknowledge. If no acknowledge comes within a cycle-count timeout, the reset goes ahead anyway. Every reset exits into Standby. A sticky status register records the cause of each reset, and software clears it by writing ones. A peripheral clock enable is also produced by dividing the bus clock by 2, 4 or 8.

Top module: `pwr_reset_ctrl`

## Requirements
- R1: When the power-on reset is released, `fullRstN` and `partRstN` go high two clock edges later. The controller is then in Standby: all five enables are low, `srefReq` is low and `rstStatus` reads 4'b0001.
- R2: While `porN` is low, `fullRstN` and `partRstN` are both low and `srefReq` stays low: no self-refresh is requested for a power-on reset.
- R3: In Standby, a `wakeEvent` moves the controller to Run. In Run, `cpuClkEn`, `busClkEn`, `mainOscEn` and `lcdEn` are all high.
- R4: In Run, command code 2'b01 (Halt) with `modeCmdValid` drops `cpuClkEn` only, keeping bus, oscillator and LCD enables high. A `wakeEvent` in Halt returns to Run.
- R5: In Run, command code 2'b10 (Standby) brings every enable low. Commands are ignored outside Run, so a Standby command given in Halt leaves the controller in Halt.
- R6: A low `pfailN` or `userRstN` raises `srefReq` while `partRstN` is still high. `partRstN` falls on the clock edge after `srefAck` is seen. `fullRstN` stays high throughout.
- R7: If `srefAck` never arrives, `partRstN` falls exactly `SREF_TIMEOUT` cycles after `srefReq` rises.
- R8: When the power-fail and user inputs are both released, the partial reset ends and the controller enters Standby, with `srefReq` low and all enables low.
- R9: `rstStatus` has four bits: bit0 power-on, bit1 power-fail, bit2 user, bit3 self-refresh timeout. The bits are sticky, and a write with `statusClrValid` clears exactly the bits set in `statusClr`.
- R10: `periClkEn` pulses once every 2, 4 or 8 cycles for `divSel` = 0, 1 or 2, and every 8 cycles for `divSel` = 3. It never pulses while `busClkEn` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| porN | input | 1 | Power-on reset, async, active low |
| pfailN | input | 1 | Power-fail reset, async, active low |
| userRstN | input | 1 | User reset, async, active low |
| modeCmdValid | input | 1 | Qualifies `modeCmd` |
| modeCmd | input | 2 | 01 = Halt, 10 = Standby, others = no action |
| wakeEvent | input | 1 | Wake from Halt or Standby |
| divSel | input | 2 | Peripheral divide select (0:/2, 1:/4, 2 and 3:/8) |
| srefAck | input | 1 | SDRAM self-refresh acknowledge |
| statusClrValid | input | 1 | Write strobe for status clear |
| statusClr | input | 4 | Write-one-to-clear mask for `rstStatus` |
| cpuClkEn | output | 1 | Processor clock enable |
| busClkEn | output | 1 | Bus clock enable |
| periClkEn | output | 1 | Divided peripheral clock enable pulse |
| mainOscEn | output | 1 | Main oscillator enable |
| lcdEn | output | 1 | Display enable |
| fullRstN | output | 1 | Full-domain reset, active low |
| partRstN | output | 1 | Partial-domain reset, active low |
| srefReq | output | 1 | Self-refresh request to SDRAM controller |
| rstStatus | output | 4 | Sticky reset cause bits |

## Verification
The hardest case to reach from the ports is a partial reset whose acknowledge never arrives. Only here does the timeout bit get set and the exact `SREF_TIMEOUT` count show. The bench holds `srefAck` low while a user reset is active. It counts cycles from the rise of `srefReq` to the fall of `partRstN`, then checks that the timeout bit is set alongside the sticky power-fail bit left by an earlier scenario.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  typedef enum logic [2:0] {
    ST_STANDBY, ST_RUN, ST_HALT, ST_SREF_WAIT, ST_PART_RST
  } pwrState_t;

  typedef struct packed {
    logic tmrRun;
    logic latchSrc;
    logic markTimeout;
    logic busOn;
  } ctlStrobe_t;

  localparam logic [1:0] CMD_HALT    = 2'b01;
  localparam logic [1:0] CMD_STANDBY = 2'b10;
endpackage

// File: rtl/pwr_rst_sync.sv
module pwr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rawN,
  output logic syncN
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rawN) begin
    if (!rawN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign syncN = chain[STAGES-1];
endmodule

// File: rtl/pwr_datapath.sv
module pwr_datapath
  import pwr_pkg::*;
#(
  parameter int SREF_TIMEOUT = 64,
  parameter int STATUS_W     = 4,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                clk,
  input  logic                porN,
  input  logic                pfailN,
  input  logic                userRstN,
  input  logic [1:0]          divSel,
  input  logic                statusClrValid,
  input  logic [STATUS_W-1:0] statusClr,
  input  ctlStrobe_t          strobe,
  output logic                porSyncN,
  output logic                pfReq,
  output logic                userReq,
  output logic                tmrDone,
  output logic                periClkEn,
  output logic [STATUS_W-1:0] rstStatus
);
  localparam int NUM_SRC = 3;
  localparam int TMR_W   = $clog2(SREF_TIMEOUT + 1);
  localparam int DIV_W   = 3;

  logic [NUM_SRC-1:0] rawN, syncN;
  assign rawN = {userRstN, pfailN, porN};

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_sync
    pwr_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rawN(rawN[i]), .syncN(syncN[i])
    );
  end

  assign porSyncN = syncN[0];
  assign pfReq    = ~syncN[1];
  assign userReq  = ~syncN[2];

  // self-refresh wait timer
  logic [TMR_W-1:0] tmrCnt;
  assign tmrDone = strobe.tmrRun && (tmrCnt == TMR_W'(SREF_TIMEOUT - 1));

  always_ff @(posedge clk or negedge porSyncN) begin
    if (!porSyncN)           tmrCnt <= '0;
    else if (!strobe.tmrRun) tmrCnt <= '0;
    else if (!tmrDone)       tmrCnt <= tmrCnt + 1'b1;
  end

  // peripheral clock divider
  logic [DIV_W-1:0] divCnt, divLast;
  always_comb begin
    case (divSel)
      2'd0:    divLast = DIV_W'(1);
      2'd1:    divLast = DIV_W'(3);
      default: divLast = DIV_W'(7);
    endcase
  end

  always_ff @(posedge clk or negedge porSyncN) begin
    if (!porSyncN)            divCnt <= '0;
    else if (!strobe.busOn)   divCnt <= '0;
    else if (divCnt >= divLast) divCnt <= '0;
    else                      divCnt <= divCnt + 1'b1;
  end

  assign periClkEn = strobe.busOn && (divCnt == divLast);

  // sticky status, write-one-to-clear
  logic [STATUS_W-1:0] setMask, clrMask;
  always_comb begin
    setMask    = '0;
    setMask[1] = strobe.latchSrc & pfReq;
    setMask[2] = strobe.latchSrc & userReq;
    setMask[3] = strobe.markTimeout;
    clrMask    = statusClrValid ? statusClr : '0;
  end

  always_ff @(posedge clk or negedge porSyncN) begin
    if (!porSyncN) rstStatus <= STATUS_W'(1);
    else           rstStatus <= (rstStatus & ~clrMask) | setMask;
  end

  assert_timer_bound_R7: assert property (@(posedge clk) disable iff (!porSyncN)
    tmrCnt < TMR_W'(SREF_TIMEOUT));

  assert_peri_spacing_R10: assert property (@(posedge clk) disable iff (!porSyncN)
    periClkEn |=> !periClkEn);

  assert_status_sticky_R9: assert property (@(posedge clk) disable iff (!porSyncN)
    (|($past(rstStatus) & ~rstStatus)) |-> $past(statusClrValid));
endmodule

// File: rtl/pwr_control.sv
module pwr_control
  import pwr_pkg::*;
(
  input  logic       clk,
  input  logic       porSyncN,
  input  logic       modeCmdValid,
  input  logic [1:0] modeCmd,
  input  logic       wakeEvent,
  input  logic       srefAck,
  input  logic       pfReq,
  input  logic       userReq,
  input  logic       tmrDone,
  output ctlStrobe_t strobe,
  output logic       cpuClkEn,
  output logic       busClkEn,
  output logic       mainOscEn,
  output logic       lcdEn,
  output logic       srefReq,
  output logic       inPartRst
);
  pwrState_t state, stateNext;
  logic anyReq, steady;

  assign anyReq = pfReq | userReq;
  assign steady = (state == ST_STANDBY) || (state == ST_RUN) || (state == ST_HALT);

  always_comb begin
    stateNext = state;
    case (state)
      ST_STANDBY:   if (anyReq) stateNext = ST_SREF_WAIT;
                    else if (wakeEvent) stateNext = ST_RUN;
      ST_RUN:       if (anyReq) stateNext = ST_SREF_WAIT;
                    else if (modeCmdValid && modeCmd == CMD_HALT) stateNext = ST_HALT;
                    else if (modeCmdValid && modeCmd == CMD_STANDBY) stateNext = ST_STANDBY;
      ST_HALT:      if (anyReq) stateNext = ST_SREF_WAIT;
                    else if (wakeEvent) stateNext = ST_RUN;
      ST_SREF_WAIT: if (srefAck || tmrDone) stateNext = ST_PART_RST;
      ST_PART_RST:  if (!anyReq) stateNext = ST_STANDBY;
      default:      stateNext = ST_STANDBY;
    endcase
  end

  always_ff @(posedge clk or negedge porSyncN) begin
    if (!porSyncN) state <= ST_STANDBY;
    else           state <= stateNext;
  end

  always_comb begin
    cpuClkEn  = 1'b0;
    busClkEn  = 1'b0;
    mainOscEn = 1'b0;
    lcdEn     = 1'b0;
    case (state)
      ST_RUN:  begin cpuClkEn = 1'b1; busClkEn = 1'b1; mainOscEn = 1'b1; lcdEn = 1'b1; end
      ST_HALT: begin busClkEn = 1'b1; mainOscEn = 1'b1; lcdEn = 1'b1; end
      ST_SREF_WAIT, ST_PART_RST: begin busClkEn = 1'b1; mainOscEn = 1'b1; end
      default: ;
    endcase
  end

  assign srefReq   = (state == ST_SREF_WAIT) || (state == ST_PART_RST);
  assign inPartRst = (state == ST_PART_RST);

  assign strobe.tmrRun      = (state == ST_SREF_WAIT);
  assign strobe.latchSrc    = steady && anyReq;
  assign strobe.markTimeout = (state == ST_SREF_WAIT) && tmrDone && !srefAck;
  assign strobe.busOn       = busClkEn;

  assert_part_after_sref_R6: assert property (@(posedge clk) disable iff (!porSyncN)
    (state == ST_PART_RST && $past(state) != ST_PART_RST) |-> $past(state) == ST_SREF_WAIT);

  assert_exit_to_standby_R8: assert property (@(posedge clk) disable iff (!porSyncN)
    (state != ST_PART_RST && $past(state) == ST_PART_RST) |-> state == ST_STANDBY);

  assert_halt_exits_R5: assert property (@(posedge clk) disable iff (!porSyncN)
    state == ST_HALT |=> (state == ST_HALT || state == ST_RUN || state == ST_SREF_WAIT));
endmodule

// File: rtl/pwr_reset_ctrl.sv
module pwr_reset_ctrl
  import pwr_pkg::*;
#(
  parameter int SREF_TIMEOUT = 64,
  parameter int STATUS_W     = 4
) (
  input  logic                clk,
  input  logic                porN,
  input  logic                pfailN,
  input  logic                userRstN,
  input  logic                modeCmdValid,
  input  logic [1:0]          modeCmd,
  input  logic                wakeEvent,
  input  logic [1:0]          divSel,
  input  logic                srefAck,
  input  logic                statusClrValid,
  input  logic [STATUS_W-1:0] statusClr,
  output logic                cpuClkEn,
  output logic                busClkEn,
  output logic                periClkEn,
  output logic                mainOscEn,
  output logic                lcdEn,
  output logic                fullRstN,
  output logic                partRstN,
  output logic                srefReq,
  output logic [STATUS_W-1:0] rstStatus
);
  ctlStrobe_t strobe;
  logic porSyncN, pfReq, userReq, tmrDone, inPartRst;

  pwr_datapath #(.SREF_TIMEOUT(SREF_TIMEOUT), .STATUS_W(STATUS_W)) u_dp (
    .clk(clk), .porN(porN), .pfailN(pfailN), .userRstN(userRstN),
    .divSel(divSel), .statusClrValid(statusClrValid), .statusClr(statusClr),
    .strobe(strobe), .porSyncN(porSyncN), .pfReq(pfReq), .userReq(userReq),
    .tmrDone(tmrDone), .periClkEn(periClkEn), .rstStatus(rstStatus)
  );

  pwr_control u_ctl (
    .clk(clk), .porSyncN(porSyncN), .modeCmdValid(modeCmdValid), .modeCmd(modeCmd),
    .wakeEvent(wakeEvent), .srefAck(srefAck), .pfReq(pfReq), .userReq(userReq),
    .tmrDone(tmrDone), .strobe(strobe), .cpuClkEn(cpuClkEn), .busClkEn(busClkEn),
    .mainOscEn(mainOscEn), .lcdEn(lcdEn), .srefReq(srefReq), .inPartRst(inPartRst)
  );

  assign fullRstN = porSyncN;
  assign partRstN = porSyncN & ~inPartRst;

  assert_full_keeps_part_R2: assert property (@(posedge clk)
    !fullRstN |-> (!partRstN && !srefReq));
endmodule

// File: tb/pwr_reset_ctrl_bench.sv
module pwr_reset_ctrl_bench;
  localparam int T = 8;

  logic clk = 1'b0;
  logic porN = 1'b0, pfailN = 1'b1, userRstN = 1'b1;
  logic modeCmdValid = 1'b0, wakeEvent = 1'b0, srefAck = 1'b0, statusClrValid = 1'b0;
  logic [1:0] modeCmd = 2'b00, divSel = 2'b00;
  logic [3:0] statusClr = 4'b0000;
  logic cpuClkEn, busClkEn, periClkEn, mainOscEn, lcdEn, fullRstN, partRstN, srefReq;
  logic [3:0] rstStatus;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pwr_reset_ctrl #(.SREF_TIMEOUT(T)) u_pwr_reset_ctrl (
    .clk(clk), .porN(porN), .pfailN(pfailN), .userRstN(userRstN),
    .modeCmdValid(modeCmdValid), .modeCmd(modeCmd), .wakeEvent(wakeEvent),
    .divSel(divSel), .srefAck(srefAck), .statusClrValid(statusClrValid),
    .statusClr(statusClr), .cpuClkEn(cpuClkEn), .busClkEn(busClkEn),
    .periClkEn(periClkEn), .mainOscEn(mainOscEn), .lcdEn(lcdEn),
    .fullRstN(fullRstN), .partRstN(partRstN), .srefReq(srefReq), .rstStatus(rstStatus)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int enables();
    return {cpuClkEn, busClkEn, mainOscEn, lcdEn};
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseCmd(input logic [1:0] code);
    modeCmd = code; modeCmdValid = 1'b1;
    @(negedge clk);
    modeCmdValid = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulseWake();
    wakeEvent = 1'b1;
    @(negedge clk);
    wakeEvent = 1'b0;
    @(negedge clk);
  endtask

  task automatic clearStatus(input logic [3:0] mask);
    statusClr = mask; statusClrValid = 1'b1;
    @(negedge clk);
    statusClrValid = 1'b0;
    @(negedge clk);
  endtask

  task automatic waitSref();
    for (int i = 0; i < 20 && !srefReq; i++) @(negedge clk);
  endtask

  task automatic testPorRelease();
    porN = 1'b0;
    idle(3);
    check(!fullRstN && !partRstN && !srefReq, "R2", {fullRstN, partRstN, srefReq}, 0);
    porN = 1'b1;
    idle(3);
    check(fullRstN && partRstN, "R1", {fullRstN, partRstN}, 3);
    check(enables() == 0 && !periClkEn && !srefReq, "R1", enables(), 0);
    check(rstStatus == 4'b0001, "R1", rstStatus, 1);
  endtask

  task automatic testRunHalt();
    pulseWake();
    check(enables() == 4'b1111, "R3", enables(), 4'hf);
    pulseCmd(2'b01);
    check(enables() == 4'b0111, "R4", enables(), 4'h7);
    pulseCmd(2'b10);
    check(enables() == 4'b0111, "R5", enables(), 4'h7);
    pulseWake();
    check(enables() == 4'b1111, "R4", enables(), 4'hf);
    pulseCmd(2'b10);
    check(enables() == 4'b0000, "R5", enables(), 0);
  endtask

  task automatic testPfailAck();
    clearStatus(4'b0001);
    check(rstStatus == 4'b0000, "R9", rstStatus, 0);
    pulseWake();
    pfailN = 1'b0;
    waitSref();
    check(srefReq && partRstN, "R6", {srefReq, partRstN}, 3);
    srefAck = 1'b1;
    @(negedge clk);
    check(!partRstN && fullRstN, "R6", {partRstN, fullRstN}, 1);
    pfailN = 1'b1;
    idle(5);
    srefAck = 1'b0;
    check(partRstN && !srefReq && enables() == 0, "R8", {partRstN, srefReq, enables()}, 6'h20);
    check(rstStatus == 4'b0010, "R9", rstStatus, 2);
  endtask

  task automatic testUserTimeout();
    int n = 0;
    pulseWake();
    userRstN = 1'b0;
    waitSref();
    while (partRstN && n < 40) begin
      @(negedge clk);
      n++;
    end
    check(n == T, "R7", n, T);
    check(rstStatus == 4'b1110, "R9", rstStatus, 4'he);
    clearStatus(4'b0100);
    check(rstStatus == 4'b1010, "R9", rstStatus, 4'ha);
    userRstN = 1'b1;
    idle(5);
    check(partRstN && enables() == 0, "R8", {partRstN, enables()}, 6'h10);
  endtask

  task automatic testDivider();
    int exp[4] = '{32, 16, 8, 8};
    pulseWake();
    for (int s = 0; s < 4; s++) begin
      int cnt = 0;
      divSel = 2'(s);
      idle(10);
      for (int i = 0; i < 64; i++) begin
        @(negedge clk);
        if (periClkEn) cnt++;
      end
      check(cnt == exp[s], "R10", cnt, exp[s]);
    end
    pulseCmd(2'b10);
    begin
      int cnt = 0;
      for (int i = 0; i < 32; i++) begin
        @(negedge clk);
        if (periClkEn) cnt++;
      end
      check(cnt == 0, "R10", cnt, 0);
    end
  endtask

  task automatic testPorInRun();
    pulseWake();
    porN = 1'b0;
    @(negedge clk);
    check(!fullRstN && !partRstN && !srefReq, "R2", {fullRstN, partRstN, srefReq}, 0);
    idle(2);
    porN = 1'b1;
    idle(3);
    check(rstStatus == 4'b0001 && enables() == 0, "R1", {rstStatus, enables()}, 8'h10);
  endtask

  initial begin
    idle(2);
    testPorRelease();
    testRunHalt();
    testPfailAck();
    testUserTimeout();
    testDivider();
    testPorInRun();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule